// File: doc/BRIEF.md
# Image Decoder Control and Status Register Bank

This block is the host-facing register bank that sits beside a streaming image decoder core. A host reaches it through a plain word-addressed register port with separate write and read strobes. The address is one word wide, and reads return data in the same cycle. The bank keeps a status word of sticky flags that the core sets by single-cycle event pulses. The host clears a flag by writing a one to its bit. Two further bits carry commands: a software reset and a start command, which resets the core and then starts it. The reset bit also acts as an idle indication.

Two of the flags mark stalls of the core: input data exhausted, and the output address window full. When the host clears either stall flag, the bank sends a one-cycle resume strobe back to the core. A mask word selects which flags may raise the single interrupt output. An interrupt is raised only when a masked flag goes from low to high. It then stays asserted until the host clears that flag.

The status word is at word address 0 and the mask word is at word address 1. Every other address reads as zero. All command and resume strobes to the core are registered and last one cycle.

Top module: `imgdec_csr`

## Requirements
- R1: After reset the status word reads 0x0000_0100 and the mask word reads 0. The reset, start, resume and interrupt outputs are all low.
- R2: An event pulse sets its status bit from the next cycle on, and the bit stays set. The bits are: done = bit 0, input empty = bit 1, output window full = bit 2, not-an-image = bit 4, corrupt = bit 5, unsupported = bit 6. Bits 31..9 always read 0.
- R3: Bit 3 (error) is set in the same cycle as bit 4, 5 or 6 whenever any of those three events arrives.
- R4: Writing 1 to any of bits 0..6 at address 0 clears that bit in the next cycle. Writing 0 leaves the bit unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: Writing 1 to bit 8 sets bit 8 and clears bits 0..6, except where an event arrives in the same cycle. It also pulses core_rst_o for one cycle, in the cycle after the write.
- R6: Writing 1 to bit 7 clears bits 0..6 and bit 8. It pulses core_rst_o in the cycle after the write and core_start_o in the cycle after that. Bit 7 always reads 0. When bits 7 and 8 are written together, the start command takes effect.
- R7: Bit 8 is cleared in any cycle in which core_idle is low and no reset command is written. While core_idle is high, bit 8 holds its value.
- R8: A write that clears a set bit 1 or a set bit 2, with no same-cycle event on that bit and no reset or start in the write, pulses core_resume_o for one cycle, in the next cycle. No other write causes this pulse.
- R9: The mask word at address 1 stores bits 8 and 6..0. Bit 7 and bits 31..9 ignore writes and read 0.
- R10: When a status bit rises while its mask bit is set (the mask value before the same cycle's write is the one that counts), irq_o goes high in the same cycle as the flag. irq_o stays high until every such flag is cleared. Changing the mask afterwards does not drop the interrupt. A flag that rises while unmasked never raises the interrupt, even if it is unmasked later.
- R11: bus_rdata is 0 when bus_rd is low or when the address is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle as bus_rd |
| ev_done | input | 1 | Core event: image finished |
| ev_in_empty | input | 1 | Core event: input data exhausted (stall) |
| ev_out_full | input | 1 | Core event: write outside output window (stall) |
| ev_notimg | input | 1 | Core event: input is not an image stream |
| ev_corrupt | input | 1 | Core event: corrupt stream |
| ev_unsup | input | 1 | Core event: unsupported format |
| core_idle | input | 1 | Core reports idle state |
| core_rst_o | output | 1 | One-cycle software reset strobe to the core |
| core_start_o | output | 1 | One-cycle start strobe, one cycle after the reset strobe |
| core_resume_o | output | 1 | One-cycle resume strobe after a stall flag is cleared |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench builds the bank with its defaults: a 32-bit data word and a 4-bit address. This puts fourteen unmapped addresses within reach for the read-as-zero checks, and leaves 23 unused upper data bits whose writes must never show. Directed passes cover the cases where a command, a clear and an event land in the same cycle. A long random pass then mixes writes, reads, events and idle changes against the model on every cycle.

// File: rtl/imgdec_csr_pkg.sv
package imgdec_csr_pkg;
  localparam int BIT_DONE    = 0;
  localparam int BIT_INEMPTY = 1;
  localparam int BIT_OUTFULL = 2;
  localparam int BIT_ERR     = 3;
  localparam int BIT_NOTIMG  = 4;
  localparam int BIT_CORRUPT = 5;
  localparam int BIT_UNSUP   = 6;
  localparam int BIT_START   = 7;
  localparam int BIT_RST     = 8;
  localparam int NUM_EVT     = 7;
  localparam int NUM_FLAGS   = 9;
  localparam logic [NUM_FLAGS-1:0] MASK_WR_BITS = 9'b1_0111_1111;
  localparam logic [NUM_FLAGS-1:0] STATUS_RST   = 9'b1_0000_0000;
endpackage

// File: rtl/imgdec_flag_cell.sv
module imgdec_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d_o,
  output logic flag_q_o
);
  // set has priority over a same-cycle clear
  assign flag_d_o = set_i | (flag_q_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q_o <= 1'b0;
    else        flag_q_o <= flag_d_o;
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q_o); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q_o); // R4
endmodule

// File: rtl/imgdec_irq_unit.sv
module imgdec_irq_unit #(
  parameter int NB = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] cur_i,
  input  logic [NB-1:0] nxt_i,
  input  logic [NB-1:0] en_i,
  output logic          irq_o
);
  logic [NB-1:0] pend_q;

  for (genvar b = 0; b < NB; b++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[b] <= 1'b0;
      else        pend_q[b] <= nxt_i[b] & (pend_q[b] | (~cur_i[b] & en_i[b]));
    end

    AST_PEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[b] |-> cur_i[b]); // R10
  end

  assign irq_o = |pend_q;
endmodule

// File: rtl/imgdec_cmd_seq.sv
module imgdec_cmd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset_i,
  input  logic start_i,
  input  logic resume_i,
  output logic core_rst_o,
  output logic core_start_o,
  output logic core_resume_o
);
  logic start_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rst_o    <= 1'b0;
      start_wait_q  <= 1'b0;
      core_start_o  <= 1'b0;
      core_resume_o <= 1'b0;
    end else begin
      core_rst_o    <= sw_reset_i;
      start_wait_q  <= start_i;
      core_start_o  <= start_wait_q;
      core_resume_o <= resume_i;
    end
  end

  AST_START_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_o |-> $past(core_rst_o)); // R6
endmodule

// File: rtl/imgdec_csr.sv
module imgdec_csr #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_done,
  input  logic              ev_in_empty,
  input  logic              ev_out_full,
  input  logic              ev_notimg,
  input  logic              ev_corrupt,
  input  logic              ev_unsup,
  input  logic              core_idle,
  output logic              core_rst_o,
  output logic              core_start_o,
  output logic              core_resume_o,
  output logic              irq_o
);
  import imgdec_csr_pkg::*;

  localparam int NF = NUM_FLAGS;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

  logic              wr_stat, wr_mask;
  logic              cmd_start, cmd_rst, sw_reset, resume_req, any_err;
  logic [NUM_EVT-1:0] ev_vec;
  logic [NF-1:0]     status_q, status_d, mask_q;
  logic              rflag_q, rflag_d;

  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_mask   = bus_wr && (bus_addr == A_MASK);
  assign cmd_start = wr_stat & bus_wdata[BIT_START];
  assign cmd_rst   = wr_stat & bus_wdata[BIT_RST];
  assign sw_reset  = cmd_start | cmd_rst;
  assign any_err   = ev_unsup | ev_corrupt | ev_notimg;

  always_comb begin
    ev_vec              = '0;
    ev_vec[BIT_DONE]    = ev_done;
    ev_vec[BIT_INEMPTY] = ev_in_empty;
    ev_vec[BIT_OUTFULL] = ev_out_full;
    ev_vec[BIT_ERR]     = any_err;
    ev_vec[BIT_NOTIMG]  = ev_notimg;
    ev_vec[BIT_CORRUPT] = ev_corrupt;
    ev_vec[BIT_UNSUP]   = ev_unsup;
  end

  // sticky event flags, one cell per bit
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    imgdec_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (ev_vec[i]),
      .clr_i    (wr_stat & (bus_wdata[i] | sw_reset)),
      .flag_d_o (status_d[i]),
      .flag_q_o (status_q[i])
    );
  end

  // reset/idle flag: start wins, then reset write, then core leaving idle
  always_comb begin
    if (cmd_start)       rflag_d = 1'b0;
    else if (cmd_rst)    rflag_d = 1'b1;
    else if (!core_idle) rflag_d = 1'b0;
    else                 rflag_d = rflag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rflag_q <= STATUS_RST[BIT_RST];
    else        rflag_q <= rflag_d;
  end

  assign status_q[BIT_START] = 1'b0;
  assign status_d[BIT_START] = 1'b0;
  assign status_q[BIT_RST]   = rflag_q;
  assign status_d[BIT_RST]   = rflag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata[NF-1:0] & MASK_WR_BITS;
  end

  assign resume_req = wr_stat & ~sw_reset &
    ((bus_wdata[BIT_INEMPTY] & status_q[BIT_INEMPTY] & ~ev_in_empty) |
     (bus_wdata[BIT_OUTFULL] & status_q[BIT_OUTFULL] & ~ev_out_full));

  imgdec_cmd_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_reset_i    (sw_reset),
    .start_i       (cmd_start),
    .resume_i      (resume_req),
    .core_rst_o    (core_rst_o),
    .core_start_o  (core_start_o),
    .core_resume_o (core_resume_o)
  );

  imgdec_irq_unit #(.NB(NF)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (status_q),
    .nxt_i (status_d),
    .en_i  (mask_q),
    .irq_o (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_STAT)      bus_rdata[NF-1:0] = status_q;
      else if (bus_addr == A_MASK) bus_rdata[NF-1:0] = mask_q;
    end
  end

  AST_RESUME_FROM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    core_resume_o |-> $past(status_q[BIT_INEMPTY] | status_q[BIT_OUTFULL])); // R8
  AST_ERR_COVERS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[BIT_UNSUP] | status_q[BIT_CORRUPT] | status_q[BIT_NOTIMG])
      |-> status_q[BIT_ERR]); // R3
  AST_RST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |=> !core_rst_o || $past(sw_reset)); // R5
endmodule

// File: tb/imgdec_csr_tb.sv
`timescale 1ns/1ps
module imgdec_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_done = 0, ev_in_empty = 0, ev_out_full = 0;
  logic        ev_notimg = 0, ev_corrupt = 0, ev_unsup = 0;
  logic        core_idle = 1'b1;
  logic        core_rst_o, core_start_o, core_resume_o, irq_o;

  always #2.5 clk = ~clk;

  imgdec_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_in_empty(ev_in_empty), .ev_out_full(ev_out_full),
    .ev_notimg(ev_notimg), .ev_corrupt(ev_corrupt), .ev_unsup(ev_unsup),
    .core_idle(core_idle), .core_rst_o(core_rst_o), .core_start_o(core_start_o),
    .core_resume_o(core_resume_o), .irq_o(irq_o)
  );

  int vectors = 0, miscompares = 0;
  bit done_flag = 0;

  // behavioural model state
  bit [8:0] m_st = 9'h100;
  bit [8:0] m_mask = '0;
  bit [8:0] m_pend = '0;
  bit m_rst = 0, m_start = 0, m_start_wait = 0, m_resume = 0;

  // ev: {unsup, corrupt, notimg, full, empty, done}
  task automatic step(input bit wr, input bit rd, input int addr, input int wd,
                      input bit [5:0] ev, input bit idle, input string req);
    bit [31:0] exp_rd;
    bit [8:0] evb, nx;
    bit srst, w0;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr[3:0]; bus_wdata = wd;
    {ev_unsup, ev_corrupt, ev_notimg, ev_out_full, ev_in_empty, ev_done} = ev;
    core_idle = idle;
    #1;
    exp_rd = 0;
    if (rd && addr == 0) exp_rd = {23'd0, m_st};
    if (rd && addr == 1) exp_rd = {23'd0, m_mask};
    vectors++;
    if (bus_rdata !== exp_rd || core_rst_o !== m_rst || core_start_o !== m_start ||
        core_resume_o !== m_resume || irq_o !== (m_pend != 0)) begin
      miscompares++;
      $display("FAIL %s: rdata=%h rst=%b start=%b resume=%b irq=%b expected rdata=%h rst=%b start=%b resume=%b irq=%b",
               req, bus_rdata, core_rst_o, core_start_o, core_resume_o, irq_o,
               exp_rd, m_rst, m_start, m_resume, (m_pend != 0));
    end
    @(posedge clk);
    w0 = wr && addr == 0;
    srst = w0 && (wd[7] || wd[8]);
    evb = '0;
    evb[0] = ev[0]; evb[1] = ev[1]; evb[2] = ev[2];
    evb[4] = ev[3]; evb[5] = ev[4]; evb[6] = ev[5];
    evb[3] = ev[3] | ev[4] | ev[5];
    for (int i = 0; i < 7; i++) begin
      bit cl;
      cl = w0 && (wd[i] || srst);
      nx[i] = evb[i] || (m_st[i] && !cl);
    end
    nx[7] = 0;
    if (w0 && wd[7]) nx[8] = 0;
    else if (w0 && wd[8]) nx[8] = 1;
    else if (!idle) nx[8] = 0;
    else nx[8] = m_st[8];
    for (int b = 0; b < 9; b++)
      m_pend[b] = nx[b] && (m_pend[b] || (!m_st[b] && m_mask[b]));
    m_resume = w0 && !srst && ((wd[1] && m_st[1] && !ev[1]) || (wd[2] && m_st[2] && !ev[2]));
    m_rst = srst;
    m_start = m_start_wait;
    m_start_wait = w0 && wd[7];
    if (wr && addr == 1) m_mask = wd[8:0] & 9'h17F;
    m_st = nx;
  endtask

  task automatic rd0(input string req);
    step(0, 1, 0, 0, 6'b0, 1, req);
  endtask

  initial begin
    fork
      begin
        #(200000 * 5);
        if (!done_flag) begin
          miscompares++;
          $display("FAIL watchdog expired");
          $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state of both words
    rd0("R1");
    step(0, 1, 1, 0, 6'b0, 1, "R1");
    // R2 event flags sticky, upper bits read zero
    step(0, 1, 0, 0, 6'b000001, 1, "R2");
    rd0("R2"); rd0("R2");
    step(0, 1, 0, 0, 6'b000110, 1, "R2");
    rd0("R2");
    // R3 error bit follows each error cause
    step(0, 1, 0, 0, 6'b010000, 1, "R3");
    rd0("R3");
    step(1, 1, 0, 32'h78, 6'b0, 1, "R3");
    step(0, 1, 0, 0, 6'b100000, 1, "R3");
    step(0, 1, 0, 0, 6'b001000, 1, "R3");
    rd0("R3");
    // R4 write zero ignored, W1C, event wins
    step(1, 1, 0, 32'hFFFF_FE00, 6'b0, 1, "R4");
    rd0("R4");
    step(1, 1, 0, 32'h1, 6'b000001, 1, "R4");
    rd0("R4");
    step(1, 1, 0, 32'h1, 6'b0, 1, "R4");
    rd0("R4");
    // R9 mask write and readback
    step(1, 1, 1, 32'hFFFF_FFFF, 6'b0, 1, "R9");
    step(0, 1, 1, 0, 6'b0, 1, "R9");
    step(1, 1, 1, 32'h0000_0080, 6'b0, 1, "R9");
    step(0, 1, 1, 0, 6'b0, 1, "R9");
    // R10 masked rise raises irq, held until cleared
    step(1, 1, 1, 32'h0000_0001, 6'b0, 1, "R10");
    step(0, 1, 0, 0, 6'b000001, 1, "R10");
    step(1, 1, 1, 32'h0, 6'b0, 1, "R10");
    rd0("R10");
    step(1, 1, 0, 32'h1, 6'b0, 1, "R10");
    rd0("R10");
    step(0, 1, 0, 0, 6'b100000, 1, "R10");
    step(1, 1, 1, 32'h40, 6'b0, 1, "R10");
    rd0("R10");
    step(1, 1, 0, 32'h7F, 6'b0, 1, "R10");
    // R8 resume strobe from stall clears
    step(0, 1, 0, 0, 6'b000010, 1, "R8");
    step(1, 1, 0, 32'h2, 6'b0, 1, "R8");
    rd0("R8");
    step(0, 1, 0, 0, 6'b000100, 1, "R8");
    step(1, 1, 0, 32'h4, 6'b000100, 1, "R8");
    rd0("R8");
    step(1, 1, 0, 32'h4, 6'b0, 1, "R8");
    rd0("R8");
    step(1, 1, 0, 32'h2, 6'b0, 1, "R8");
    rd0("R8");
    // R5 software reset command
    step(0, 1, 0, 0, 6'b100101, 1, "R5");
    step(1, 1, 0, 32'h100, 6'b000001, 1, "R5");
    rd0("R5"); rd0("R5");
    // R6 start command, bit 7 reads zero, combined with bit 8
    step(0, 1, 0, 0, 6'b000011, 1, "R6");
    step(1, 1, 0, 32'h80, 6'b0, 1, "R6");
    rd0("R6"); rd0("R6"); rd0("R6");
    step(1, 1, 0, 32'h180, 6'b0, 1, "R6");
    rd0("R6"); rd0("R6");
    step(1, 1, 0, 32'h100, 6'b0, 1, "R6");
    // R7 reset flag drops when core leaves idle
    rd0("R7");
    step(0, 1, 0, 0, 6'b0, 0, "R7");
    rd0("R7");
    step(1, 1, 0, 32'h100, 6'b0, 0, "R7");
    rd0("R7");
    // R11 unmapped addresses and idle read port
    step(0, 1, 5, 0, 6'b0, 1, "R11");
    step(0, 1, 15, 0, 6'b0, 1, "R11");
    step(0, 0, 0, 0, 6'b0, 1, "R11");
    // random mix exercising R2 R4 R5 R8 R10 together
    for (int n = 0; n < 4000; n++) begin
      int a, w, r;
      bit [5:0] e;
      r = $urandom_range(0, 99);
      a = (r < 70) ? 0 : (r < 85) ? 1 : $urandom_range(0, 15);
      w = $urandom;
      if ($urandom_range(0, 19) != 0) w = w & 32'hFFFF_FE7F;
      e = '0;
      for (int k = 0; k < 6; k++) e[k] = ($urandom_range(0, 9) == 0);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 7) != 0, a, w, e,
           $urandom_range(0, 9) != 0, "R2 R4 R8 R10 random");
    end
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule